// File: doc/BRIEF.md
# Register-Driven Multiply-Accumulate Unit

This peripheral does multiplication for a processor that has no multiply instruction. Software writes a first operand to one of four write addresses, and the address it picks sets the operation: unsigned product, signed product, unsigned accumulate or signed accumulate. Software then writes the second operand. That write starts the operation. The 32-bit result and an extension word are captured on the same clock edge that accepts the second operand. A read issued in the very next bus cycle therefore already returns the new result.

Each operand accepts either a full word or a single byte. A byte arrives on the low lane and is widened according to the signedness of the operation. This is how 8x8, 8x16, 16x8 and 16x16 products are formed. In the accumulate operations the new product is added to the 32-bit value held in the two result words. Software can preload those two words before it starts a chain of accumulates. If only the second operand is written again, the last selected operation repeats with the first operand that is still held.

Top module: `mmac_unit`

## Requirements
- R1: After reset every readable register (both operands, both result words and the extension word) reads as zero, and the selected operation is the unsigned product.
- R2: The word address of a first-operand write selects the operation: 0 gives the unsigned product, 1 the signed product, 2 the unsigned accumulate and 3 the signed accumulate. In the unsigned product the 32-bit result is the unsigned product and the extension word is 0x0000.
- R3: In the signed product the result is the two's-complement product, and the extension word is 0xFFFF when that product is negative and 0x0000 otherwise.
- R4: In the unsigned accumulate the unsigned product is added to the previous 32-bit result modulo 2^32, and the extension word is the carry out of that sum (0x0000 or 0x0001).
- R5: In the signed accumulate the signed product is added to the previous 32-bit result modulo 2^32 with no saturation, and the extension word is 0xFFFF when bit 31 of the sum is set and 0x0000 otherwise.
- R6: A byte write to a first-operand address takes bits 7:0 and sign-extends them to 16 bits when the address selects a signed operation (odd address). It zero-extends them otherwise.
- R7: A byte write to the second operand (address 4) is sign-extended when the currently selected operation is signed and zero-extended when it is unsigned.
- R8: The result of an operation can be read by a read issued in the bus cycle right after the second-operand write. Read data is returned one cycle after the read strobe.
- R9: Writing the second operand again without a new first-operand write repeats the selected operation with the retained first operand. In the accumulate operations this adds to the result just produced.
- R10: Word writes to address 5 (result low) and address 6 (result high) preload the 32-bit accumulator. A write to address 7 (extension) has no effect.
- R11: Reading any of addresses 0 to 3 returns the stored, already extended first operand, and reading address 4 returns the stored second operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_byte | input | 1 | 1 = byte write using bits 7:0 of bus_wdata |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Register word address (0-3 first operand, 4 second operand, 5/6 result, 7 extension) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data, valid the cycle after bus_rd |

## Verification
The bench goes after the sign-sensitive edges. These include -1 times -1, 0x8000 times 0x8000 and 0xFFFF times 0xFFFF read as unsigned. A design that mixed up signed and unsigned widening would return the wrong high word or extension word for these. Accumulate chains start from preloaded values of 0xFFFFFFFF and 0x7FFFFFFF. Those values expose a missing carry in the extension word and any saturation, or a sign taken from the product instead of from the sum. Byte writes to both operands are checked under both signednesses, because widening op2 by the address rather than by the held mode gives 0x00FF where 0xFFFF is due. A second-operand-only rewrite after an accumulate catches a design that clears the accumulator or forgets the mode. Reads placed directly after the starting write catch a result that lags by a cycle.

// File: rtl/mmac_pkg.sv
package mmac_pkg;

  // bit 0: signed, bit 1: accumulate (decoded from op1 address bits)
  typedef enum logic [1:0] {
    MODE_UMUL = 2'd0,
    MODE_SMUL = 2'd1,
    MODE_UMAC = 2'd2,
    MODE_SMAC = 2'd3
  } mac_mode_e;

  localparam int unsigned REG_ADDR_W = 3;

  localparam logic [REG_ADDR_W-1:0] A_OP2     = 3'd4;
  localparam logic [REG_ADDR_W-1:0] A_RES_LO  = 3'd5;
  localparam logic [REG_ADDR_W-1:0] A_RES_HI  = 3'd6;
  localparam logic [REG_ADDR_W-1:0] A_RES_EXT = 3'd7;

  function automatic logic mode_is_signed(mac_mode_e m);
    return m[0];
  endfunction

  function automatic logic mode_is_accum(mac_mode_e m);
    return m[1];
  endfunction

endpackage

// File: rtl/mmac_opnd_regs.sv
module mmac_opnd_regs
  import mmac_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  wr_byte,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     op1,
  output logic [DATA_W-1:0]     op2,
  output logic [DATA_W-1:0]     op2_next,
  output mac_mode_e             mode,
  output logic                  op2_wr
);

  localparam int unsigned PAD_W = DATA_W - BYTE_W;

  logic            op1_wr;
  logic [DATA_W-1:0] op1_next;

  function automatic logic [DATA_W-1:0] widen(logic [DATA_W-1:0] d,
                                              logic byte_mode,
                                              logic sgn);
    logic [DATA_W-1:0] r;
    if (byte_mode) r = {{PAD_W{sgn & d[BYTE_W-1]}}, d[BYTE_W-1:0]};
    else           r = d;
    return r;
  endfunction

  assign op1_wr   = wr_en && (addr[REG_ADDR_W-1] == 1'b0);
  assign op2_wr   = wr_en && (addr == A_OP2);
  assign op1_next = widen(wdata, wr_byte, addr[0]);
  assign op2_next = widen(wdata, wr_byte, mode_is_signed(mode));

  always_ff @(posedge clk) begin
    if (rst) begin
      op1  <= '0;
      op2  <= '0;
      mode <= MODE_UMUL;
    end else begin
      if (op1_wr) begin
        op1  <= op1_next;
        mode <= mac_mode_e'(addr[1:0]);
      end
      if (op2_wr) op2 <= op2_next;
    end
  end

  // R9
  op1_retained_chk: assert property (@(posedge clk) disable iff (rst)
    op2_wr |=> ($stable(op1) && $stable(mode)))
    else $error("op1 or mode changed on op2-only write");

endmodule

// File: rtl/mmac_datapath.sv
module mmac_datapath
  import mmac_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0]   a,
  input  logic [DATA_W-1:0]   b,
  input  mac_mode_e           mode,
  input  logic [2*DATA_W-1:0] acc,
  output logic [2*DATA_W-1:0] res,
  output logic [DATA_W-1:0]   ext
);

  localparam int unsigned RES_W = 2 * DATA_W;

  logic             sgn;
  logic [RES_W-1:0] a_w, b_w, prod;
  logic [RES_W:0]   sum;

  assign sgn  = mode_is_signed(mode);
  assign a_w  = {{DATA_W{sgn & a[DATA_W-1]}}, a};
  assign b_w  = {{DATA_W{sgn & b[DATA_W-1]}}, b};
  assign prod = a_w * b_w;
  assign sum  = {1'b0, acc} + {1'b0, prod};

  always_comb begin
    unique case (mode)
      MODE_UMUL: begin
        res = prod;
        ext = '0;
      end
      MODE_SMUL: begin
        res = prod;
        ext = {DATA_W{prod[RES_W-1]}};
      end
      MODE_UMAC: begin
        res = sum[RES_W-1:0];
        ext = {{(DATA_W-1){1'b0}}, sum[RES_W]};
      end
      default: begin
        res = sum[RES_W-1:0];
        ext = {DATA_W{sum[RES_W-1]}};
      end
    endcase
  end

endmodule

// File: rtl/mmac_result_regs.sv
module mmac_result_regs
  import mmac_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic [2*DATA_W-1:0]   new_res,
  input  logic [DATA_W-1:0]     new_ext,
  input  mac_mode_e             mode,
  input  logic                  wr_en,
  input  logic                  wr_byte,
  input  logic                  rd_en,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [DATA_W-1:0]     op1,
  input  logic [DATA_W-1:0]     op2,
  output logic [2*DATA_W-1:0]   acc,
  output logic [DATA_W-1:0]     ext,
  output logic [DATA_W-1:0]     rdata
);

  localparam int unsigned RES_W = 2 * DATA_W;

  logic [DATA_W-1:0] res_lo, res_hi, pre_val;

  assign acc     = {res_hi, res_lo};
  assign pre_val = wr_byte ? {{(DATA_W-BYTE_W){1'b0}}, wdata[BYTE_W-1:0]} : wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_lo <= '0;
      res_hi <= '0;
      ext    <= '0;
    end else if (load) begin
      res_lo <= new_res[DATA_W-1:0];
      res_hi <= new_res[RES_W-1:DATA_W];
      ext    <= new_ext;
    end else if (wr_en) begin
      if (addr == A_RES_LO) res_lo <= pre_val;
      if (addr == A_RES_HI) res_hi <= pre_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      unique case (addr)
        A_OP2:     rdata <= op2;
        A_RES_LO:  rdata <= res_lo;
        A_RES_HI:  rdata <= res_hi;
        A_RES_EXT: rdata <= ext;
        default:   rdata <= op1;
      endcase
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (acc == '0 && ext == '0 && rdata == '0))
    else $error("state not cleared by reset");

  // R2
  umul_ext_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (load && mode == MODE_UMUL) |=> (ext == '0))
    else $error("extension nonzero after unsigned product");

  // R3
  smul_ext_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (load && mode == MODE_SMUL) |=> (ext == {DATA_W{res_hi[DATA_W-1]}}))
    else $error("extension does not follow signed product sign");

  // R4
  umac_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (load && mode == MODE_UMAC) |=> (ext[DATA_W-1:1] == '0))
    else $error("unsigned accumulate extension wider than a carry");

  // R5
  smac_ext_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (load && mode == MODE_SMAC) |=> (ext == {DATA_W{res_hi[DATA_W-1]}}))
    else $error("extension does not follow accumulated sign");

  // R10
  ext_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_RES_EXT) |=> $stable(ext))
    else $error("write to extension word changed it");

endmodule

// File: rtl/mmac_unit.sv
module mmac_unit
  import mmac_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_wr,
  input  logic                  bus_byte,
  input  logic                  bus_rd,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata
);

  localparam int unsigned RES_W = 2 * DATA_W;

  logic [DATA_W-1:0] op1, op2, op2_next, new_ext, ext;
  logic [RES_W-1:0]  acc, new_res;
  logic              op2_wr;
  mac_mode_e         mode;

  mmac_opnd_regs #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_opnd (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (bus_wr),
    .wr_byte  (bus_byte),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .op1      (op1),
    .op2      (op2),
    .op2_next (op2_next),
    .mode     (mode),
    .op2_wr   (op2_wr)
  );

  mmac_datapath #(.DATA_W(DATA_W)) u_dp (
    .a    (op1),
    .b    (op2_next),
    .mode (mode),
    .acc  (acc),
    .res  (new_res),
    .ext  (new_ext)
  );

  mmac_result_regs #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_res (
    .clk     (clk),
    .rst     (rst),
    .load    (op2_wr),
    .new_res (new_res),
    .new_ext (new_ext),
    .mode    (mode),
    .wr_en   (bus_wr),
    .wr_byte (bus_byte),
    .rd_en   (bus_rd),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .op1     (op1),
    .op2     (op2),
    .acc     (acc),
    .ext     (ext),
    .rdata   (bus_rdata)
  );

endmodule

// File: tb/test_mmac_unit.sv
`timescale 1ns/1ps
module test_mmac_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_byte = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [15:0] val;
    string       tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  // model state
  logic [15:0] m_op1 = '0, m_op2 = '0, m_lo = '0, m_hi = '0, m_ext = '0;
  logic [1:0]  m_mode = '0;

  always #2 clk = ~clk;

  mmac_unit i_mmac_unit (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_byte(bus_byte), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic logic [15:0] widen(logic [15:0] d, bit byt, bit sg);
    if (!byt) return d;
    return {{8{sg & d[7]}}, d[7:0]};
  endfunction

  function automatic void model_run();
    longint a, b, prod;
    logic [63:0] s;
    logic [31:0] p32, acc, r;
    if (m_mode[0]) begin
      a = longint'($signed(m_op1));
      b = longint'($signed(m_op2));
    end else begin
      a = longint'(m_op1);
      b = longint'(m_op2);
    end
    prod = a * b;
    p32  = prod[31:0];
    acc  = {m_hi, m_lo};
    case (m_mode)
      2'd0: begin r = p32; m_ext = 16'h0000; end
      2'd1: begin r = p32; m_ext = (prod < 0) ? 16'hFFFF : 16'h0000; end
      2'd2: begin
        s = {32'd0, acc} + {32'd0, p32};
        r = s[31:0];
        m_ext = {15'd0, s[32]};
      end
      default: begin
        s = {32'd0, acc} + {32'd0, p32};
        r = s[31:0];
        m_ext = r[31] ? 16'hFFFF : 16'h0000;
      end
    endcase
    m_lo = r[15:0];
    m_hi = r[31:16];
  endfunction

  // driver: called at a falling edge, returns at the next falling edge
  task automatic wr(input logic [2:0] a, input logic [15:0] d, input bit byt);
    bus_wr = 1'b1; bus_byte = byt; bus_addr = a; bus_wdata = d;
    if (a < 3'd4) begin
      m_mode = a[1:0];
      m_op1  = widen(d, byt, a[0]);
    end else if (a == 3'd4) begin
      m_op2 = widen(d, byt, m_mode[0]);
      model_run();
    end else if (a == 3'd5) begin
      m_lo = byt ? {8'd0, d[7:0]} : d;
    end else if (a == 3'd6) begin
      m_hi = byt ? {8'd0, d[7:0]} : d;
    end
    @(negedge clk);
    bus_wr = 1'b0; bus_byte = 1'b0;
  endtask

  task automatic rd_exp(input logic [2:0] a, input logic [15:0] e, input string tag);
    sb_item_t it;
    it.val = e; it.tag = tag;
    sb_q.push_back(it);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    logic [15:0] e;
    case (a)
      3'd4: e = m_op2;
      3'd5: e = m_lo;
      3'd6: e = m_hi;
      3'd7: e = m_ext;
      default: e = m_op1;
    endcase
    rd_exp(a, e, tag);
  endtask

  task automatic rd_result(input string tag);
    rd(3'd5, tag); rd(3'd6, tag); rd(3'd7, tag);
  endtask

  // monitor
  logic pend = 1'b0;
  always @(posedge clk) pend <= rst ? 1'b0 : bus_rd;

  always @(negedge clk) begin
    if (pend) begin
      sb_item_t it;
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: read data 0x%04h with nothing expected", bus_rdata);
      end else begin
        it = sb_q.pop_front();
        if (bus_rdata !== it.val) begin
          errors++;
          $display("FAIL %s: got 0x%04h expected 0x%04h", it.tag, bus_rdata, it.val);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    for (int i = 0; i < 8; i++) rd_exp(3'(i), 16'h0000, "R1 reset value");

    // R2 / R8: unsigned product, read right after start
    wr(3'd0, 16'hFFFF, 0); wr(3'd4, 16'hFFFF, 0);
    rd_exp(3'd5, 16'h0001, "R8 R2 lo"); rd_exp(3'd6, 16'hFFFE, "R2 hi"); rd_exp(3'd7, 16'h0000, "R2 ext");
    wr(3'd0, 16'h1234, 0); wr(3'd4, 16'h5678, 0);
    rd_result("R2 0x1234*0x5678");

    // R3: signed product
    wr(3'd1, 16'hFFFF, 0); wr(3'd4, 16'h0003, 0);
    rd_exp(3'd5, 16'hFFFD, "R3 lo"); rd_exp(3'd6, 16'hFFFF, "R3 hi"); rd_exp(3'd7, 16'hFFFF, "R3 ext neg");
    wr(3'd4, 16'hFFFF, 0);
    rd_exp(3'd5, 16'h0001, "R9 R3 -1*-1 lo"); rd_exp(3'd7, 16'h0000, "R3 ext pos");
    wr(3'd1, 16'h8000, 0); wr(3'd4, 16'h8000, 0);
    rd_exp(3'd6, 16'h4000, "R3 0x8000^2 hi"); rd_result("R3 0x8000^2");
    wr(3'd4, 16'h0005, 0);
    rd_result("R9 repeat signed product");

    // R10 / R4: preload then unsigned accumulate with carry
    wr(3'd5, 16'hFFFF, 0); wr(3'd6, 16'hFFFF, 0);
    rd_exp(3'd5, 16'hFFFF, "R10 preload lo"); rd_exp(3'd6, 16'hFFFF, "R10 preload hi");
    wr(3'd2, 16'h0001, 0); wr(3'd4, 16'h0001, 0);
    rd_exp(3'd5, 16'h0000, "R4 lo"); rd_exp(3'd6, 16'h0000, "R4 hi"); rd_exp(3'd7, 16'h0001, "R4 carry");
    wr(3'd4, 16'h0002, 0);
    rd_exp(3'd5, 16'h0002, "R9 repeat accumulate lo"); rd_exp(3'd7, 16'h0000, "R4 no carry");
    wr(3'd2, 16'hFFFF, 0); wr(3'd4, 16'hFFFF, 0);
    rd_result("R4 large unsigned accumulate");
    wr(3'd7, 16'h1234, 0);
    rd_exp(3'd7, m_ext, "R10 extension write ignored");

    // R5: signed accumulate wraps without saturation
    wr(3'd5, 16'hFFFF, 0); wr(3'd6, 16'h7FFF, 0);
    wr(3'd3, 16'h0001, 0); wr(3'd4, 16'h0001, 0);
    rd_exp(3'd5, 16'h0000, "R5 lo"); rd_exp(3'd6, 16'h8000, "R5 wrap hi"); rd_exp(3'd7, 16'hFFFF, "R5 ext neg");
    wr(3'd3, 16'hFFFE, 0); wr(3'd4, 16'h0001, 0);
    rd_exp(3'd6, 16'h7FFF, "R5 back hi"); rd_exp(3'd7, 16'h0000, "R5 ext pos");
    rd_result("R5 chain");

    // R6 / R11: byte writes to op1
    wr(3'd1, 16'h3480, 1);
    rd_exp(3'd1, 16'hFF80, "R6 R11 signed byte op1");
    rd_exp(3'd2, 16'hFF80, "R11 op1 alias");
    wr(3'd0, 16'h3480, 1);
    rd_exp(3'd0, 16'h0080, "R6 unsigned byte op1");

    // R7: byte writes to op2
    wr(3'd4, 16'h12FF, 1);
    rd_exp(3'd4, 16'h00FF, "R7 R11 unsigned byte op2");
    rd_result("R7 8x8 unsigned");
    wr(3'd1, 16'h0002, 0); wr(3'd4, 16'h12FF, 1);
    rd_exp(3'd4, 16'hFFFF, "R7 signed byte op2");
    rd_exp(3'd5, 16'hFFFE, "R7 16x8 signed lo"); rd_exp(3'd7, 16'hFFFF, "R7 ext");
    wr(3'd3, 16'h00F0, 1); wr(3'd4, 16'h0010, 1);
    rd_result("R7 R5 8x8 signed accumulate");

    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: %0d reads unanswered, expected 0", sb_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule